// File: doc/BRIEF.md
# Multi-Channel Interval Timer Bank

This block holds a parameterised number of 32-bit interval timers behind a small word-addressed register bus. Each channel has three visible registers: a control/status word, a reload value and a live counter. Software programs the reload value, then writes the control word with the run bit set. That write copies the reload value into the counter. From then on the counter steps by one on every cycle in which the shared `tickEn` input is high, counting up or down as the control word selects.

When a channel reaches its terminal value and one more tick arrives, the channel has expired. It raises a sticky interrupt flag. If auto-reload is enabled, it copies the reload value into the counter again and keeps running. Otherwise it stops and clears its own run bit. Software clears a flag by writing a one to that bit position. All channels drive one interrupt line, and a channel contributes to it only while its interrupt-enable bit is set.

Reads are combinational from the address. Writes take effect at the clock edge on which `regWr` is high.

Top module: `ivl_timer_bank`

## Requirements
- R1: After reset every register of every channel reads zero, and `irqOut` is low.
- R2: The channel index is `regAddr[ADDR_W-1:2]` and the register within the channel is `regAddr[1:0]`: 0 is control/status, 1 is reload value, 2 is counter and 3 is spare. The counter is read-only; a write to it is ignored. The spare slot always reads zero.
- R3: A control write stores bits 0–7, 9 and 10 of the write data. Bits 11–31 of the control register read back as zero.
- R4: Bit 8 of the control register is the interrupt flag. Writing 1 to it clears the flag, and writing 0 to it leaves the flag as it was.
- R5: A control write with bit 7 (run) set loads the counter from the reload register. If a tick arrives in the same cycle, the write takes priority over it.
- R6: With bit 1 set (count down), a running channel decrements once per tick. A tick that arrives while the counter is zero causes an expiry.
- R7: With bit 1 clear (count up), a running channel increments once per tick. A tick that arrives while the counter is all-ones causes an expiry.
- R8: An expiry sets the interrupt flag. With bit 4 (auto-reload) set, the counter reloads and the channel keeps running. With bit 4 clear, the counter keeps its terminal value and the run bit clears.
- R9: While bit 5 (hold) is set, the counter follows the reload register and neither counts nor expires.
- R10: Clearing the run bit freezes the counter at its current value and leaves the interrupt flag unchanged.
- R11: `irqOut` is high exactly when at least one channel has both its interrupt flag and bit 6 (interrupt enable) set.
- R12: In a cycle where `tickEn` is low, no counter changes unless a register write makes it change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Count strobe shared by all channels |
| regWr | input | 1 | Write strobe for the register bus |
| regAddr | input | ADDR_W | Word address: channel index above a 2-bit register offset |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data for `regAddr` (combinational) |
| irqOut | output | 1 | Shared interrupt |

## Verification
The assertions check, on every cycle, the rules that apply one step at a time. These are:
- a single decrement or increment per tick;
- a frozen counter while the run bit is clear or no tick arrives;
- the counter tracking the reload value while hold is set;
- write-one-to-clear of the flag;
- no flag rise without a tick;
- at most one write strobe at a time.

Only the bench scenarios can show complete sequences. These include the expiry point after a programmed number of ticks, reload versus stop, the bit mask of the control readback, ignored writes to the counter, and the shared interrupt line as several channels raise and clear flags under different enable settings.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

  localparam int CTRL_W = 11;
  localparam int OFS_W  = 2;

  // Control/status bit positions (software decodes these)
  localparam int CB_MODE = 0;   // stored only
  localparam int CB_DOWN = 1;
  localparam int CB_GEN  = 2;   // stored only
  localparam int CB_CAPT = 3;   // stored only
  localparam int CB_AUTO = 4;
  localparam int CB_HOLD = 5;
  localparam int CB_IEN  = 6;
  localparam int CB_RUN  = 7;
  localparam int CB_FLAG = 8;
  localparam int CB_PWM  = 9;   // stored only
  localparam int CB_ALL  = 10;  // stored only

  // Bits taken directly from a control write (flag handled separately)
  localparam logic [CTRL_W-1:0] CTRL_WR_MASK = 11'b110_1111_1111;

  typedef enum logic [OFS_W-1:0] {
    OFS_CTRL  = 2'd0,
    OFS_LOAD  = 2'd1,
    OFS_COUNT = 2'd2,
    OFS_SPARE = 2'd3
  } regOfs_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrLoad;
  } chanStrobe_t;

endpackage

// File: rtl/ivl_timer_chan.sv
module ivl_timer_chan
  import ivl_timer_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  chanStrobe_t       strobe,
  input  logic [DATA_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrlReg,
  output logic [DATA_W-1:0] loadReg,
  output logic [DATA_W-1:0] countReg,
  output logic              irqReq
);

  logic atEnd;
  logic countDown;
  logic stepOk;

  assign countDown = ctrlReg[CB_DOWN];
  assign atEnd     = countDown ? (countReg == '0) : (countReg == '1);
  assign stepOk    = ctrlReg[CB_RUN] && !ctrlReg[CB_HOLD] && tickEn;
  assign irqReq    = ctrlReg[CB_FLAG] && ctrlReg[CB_IEN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      loadReg  <= '0;
      countReg <= '0;
    end else begin
      if (strobe.wrLoad) begin
        loadReg <= wdata;
      end
      if (strobe.wrCtrl) begin
        ctrlReg          <= wdata[CTRL_W-1:0] & CTRL_WR_MASK;
        ctrlReg[CB_FLAG] <= ctrlReg[CB_FLAG] & ~wdata[CB_FLAG];
        if (wdata[CB_RUN] || wdata[CB_HOLD]) begin
          countReg <= loadReg;
        end
      end else if (ctrlReg[CB_HOLD]) begin
        countReg <= loadReg;
      end else if (stepOk) begin
        if (atEnd) begin
          ctrlReg[CB_FLAG] <= 1'b1;
          if (ctrlReg[CB_AUTO]) begin
            countReg <= loadReg;
          end else begin
            ctrlReg[CB_RUN] <= 1'b0;
          end
        end else if (countDown) begin
          countReg <= countReg - 1'b1;
        end else begin
          countReg <= countReg + 1'b1;
        end
      end
    end
  end

  // R6: single decrement per tick
  a_r6_down_step: assert property (@(posedge clk) disable iff (!rstN)
    (stepOk && countDown && !strobe.wrCtrl && countReg != '0)
      |=> countReg == $past(countReg) - 1'b1);

  // R7: single increment per tick
  a_r7_up_step: assert property (@(posedge clk) disable iff (!rstN)
    (stepOk && !countDown && !strobe.wrCtrl && countReg != '1)
      |=> countReg == $past(countReg) + 1'b1);

  // R9: hold tracks the reload value
  a_r9_hold_follow: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg[CB_HOLD] && !strobe.wrCtrl) |=> countReg == $past(loadReg));

  // R10: stopped counter is frozen
  a_r10_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlReg[CB_RUN] && !ctrlReg[CB_HOLD] && !strobe.wrCtrl) |=> $stable(countReg));

  // R12: no tick, no change
  a_r12_no_tick: assert property (@(posedge clk) disable iff (!rstN)
    (!tickEn && !ctrlReg[CB_HOLD] && !strobe.wrCtrl) |=> $stable(countReg));

  // R4: write-one clears the flag
  a_r4_flag_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrCtrl && wdata[CB_FLAG]) |=> !ctrlReg[CB_FLAG]);

  // R8: flag rises only on a tick
  a_r8_flag_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrlReg[CB_FLAG]) |-> $past(tickEn));

endmodule

// File: rtl/ivl_timer_datapath.sv
module ivl_timer_datapath
  import ivl_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           tickEn,
  input  chanStrobe_t [NUM_CH-1:0]       strobes,
  input  logic [DATA_W-1:0]              wdata,
  output logic [NUM_CH-1:0][CTRL_W-1:0]  chanCtrl,
  output logic [NUM_CH-1:0][DATA_W-1:0]  chanLoad,
  output logic [NUM_CH-1:0][DATA_W-1:0]  chanCount,
  output logic [NUM_CH-1:0]              irqReq
);

  for (genvar i = 0; i < NUM_CH; i++) begin : gChan
    ivl_timer_chan #(.DATA_W(DATA_W)) uChan (
      .clk     (clk),
      .rstN    (rstN),
      .tickEn  (tickEn),
      .strobe  (strobes[i]),
      .wdata   (wdata),
      .ctrlReg (chanCtrl[i]),
      .loadReg (chanLoad[i]),
      .countReg(chanCount[i]),
      .irqReq  (irqReq[i])
    );
  end

endmodule

// File: rtl/ivl_timer_ctrl.sv
module ivl_timer_ctrl
  import ivl_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  parameter int CH_W   = 1,
  localparam int ADDR_W = CH_W + OFS_W
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           regWr,
  input  logic [ADDR_W-1:0]              regAddr,
  input  logic [NUM_CH-1:0][CTRL_W-1:0]  chanCtrl,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  chanLoad,
  input  logic [NUM_CH-1:0][DATA_W-1:0]  chanCount,
  output chanStrobe_t [NUM_CH-1:0]       strobes,
  output logic [DATA_W-1:0]              regRdata
);

  logic [CH_W-1:0] chanIdx;
  regOfs_e         regOfs;

  assign chanIdx = regAddr[ADDR_W-1:OFS_W];
  assign regOfs  = regOfs_e'(regAddr[OFS_W-1:0]);

  always_comb begin
    for (int i = 0; i < NUM_CH; i++) begin
      strobes[i].wrCtrl = regWr && (chanIdx == CH_W'(i)) && (regOfs == OFS_CTRL);
      strobes[i].wrLoad = regWr && (chanIdx == CH_W'(i)) && (regOfs == OFS_LOAD);
    end
  end

  always_comb begin
    regRdata = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chanIdx == CH_W'(i)) begin
        unique case (regOfs)
          OFS_CTRL:  regRdata = DATA_W'(chanCtrl[i]);
          OFS_LOAD:  regRdata = chanLoad[i];
          OFS_COUNT: regRdata = chanCount[i];
          OFS_SPARE: regRdata = '0;
        endcase
      end
    end
  end

  // R2: at most one register written per cycle
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

  // R2: counter and spare slots never produce a write
  a_r2_ro_slots: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && (regOfs == OFS_COUNT || regOfs == OFS_SPARE)) |-> (strobes == '0));

endmodule

// File: rtl/ivl_timer_bank.sv
module ivl_timer_bank
  import ivl_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DATA_W = 32,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = CH_W + OFS_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic              irqOut
);

  chanStrobe_t [NUM_CH-1:0]       strobes;
  logic [NUM_CH-1:0][CTRL_W-1:0]  chanCtrl;
  logic [NUM_CH-1:0][DATA_W-1:0]  chanLoad;
  logic [NUM_CH-1:0][DATA_W-1:0]  chanCount;
  logic [NUM_CH-1:0]              irqReq;

  ivl_timer_ctrl #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W),
    .CH_W  (CH_W)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWr    (regWr),
    .regAddr  (regAddr),
    .chanCtrl (chanCtrl),
    .chanLoad (chanLoad),
    .chanCount(chanCount),
    .strobes  (strobes),
    .regRdata (regRdata)
  );

  ivl_timer_datapath #(
    .NUM_CH(NUM_CH),
    .DATA_W(DATA_W)
  ) uData (
    .clk      (clk),
    .rstN     (rstN),
    .tickEn   (tickEn),
    .strobes  (strobes),
    .wdata    (regWdata),
    .chanCtrl (chanCtrl),
    .chanLoad (chanLoad),
    .chanCount(chanCount),
    .irqReq   (irqReq)
  );

  assign irqOut = |irqReq;

  // R11: interrupt low out of reset until a flag can exist
  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> ($past(tickEn) || $past(regWr)));

endmodule

// File: tb/ivl_timer_bank_test.sv
module ivl_timer_bank_test;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tickEn = 1'b0;
  logic              regWr = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [DATA_W-1:0] regWdata = '0;
  logic [DATA_W-1:0] regRdata;
  logic              irqOut;

  int checks = 0;
  int fails  = 0;

  always #4ns clk = ~clk;

  ivl_timer_bank uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .regWr(regWr),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        isWr;
    logic [2:0]  addr;
    logic [31:0] data;
    logic [3:0]  ticks;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 3'd1, 32'h3,        4'd0, 8'd2},   // R2 reload ch0
    '{1'b0, 3'd1, 32'h3,        4'd0, 8'd2},   // R2
    '{1'b1, 3'd0, 32'hC2,       4'd0, 8'd5},   // R5 down, ien, run
    '{1'b0, 3'd2, 32'h3,        4'd2, 8'd5},   // R5 counter loaded
    '{1'b0, 3'd2, 32'h1,        4'd2, 8'd6},   // R6 after two ticks; then 0, expiry
    '{1'b0, 3'd0, 32'h142,      4'd0, 8'd8},   // R8 flag set, run cleared
    '{1'b0, 3'd2, 32'h0,        4'd0, 8'd8},   // R8 terminal value kept
    '{1'b1, 3'd0, 32'h100,      4'd0, 8'd4},   // R4 clear flag
    '{1'b0, 3'd0, 32'h0,        4'd0, 8'd4},   // R4
    '{1'b1, 3'd5, 32'hFFFFFFFD, 4'd0, 8'd7},   // R7 reload ch1
    '{1'b1, 3'd4, 32'h90,       4'd2, 8'd7},   // R7 up, auto, run
    '{1'b0, 3'd6, 32'hFFFFFFFF, 4'd1, 8'd7},   // R7 at all-ones, then expiry
    '{1'b0, 3'd4, 32'h190,      4'd0, 8'd8},   // R8 flag set, still running
    '{1'b0, 3'd6, 32'hFFFFFFFD, 4'd0, 8'd8},   // R8 reloaded
    '{1'b1, 3'd6, 32'h55,       4'd0, 8'd2},   // R2 counter write ignored
    '{1'b0, 3'd6, 32'hFFFFFFFD, 4'd0, 8'd2},   // R2
    '{1'b0, 3'd7, 32'h0,        4'd0, 8'd2},   // R2 spare reads zero
    '{1'b1, 3'd4, 32'h10,       4'd3, 8'd10},  // R10 stop, flag kept
    '{1'b0, 3'd4, 32'h110,      4'd0, 8'd10},  // R10
    '{1'b0, 3'd6, 32'hFFFFFFFD, 4'd0, 8'd10},  // R10 frozen
    '{1'b1, 3'd0, 32'hFFFFFFFF, 4'd2, 8'd9},   // R9 all bits, hold on
    '{1'b0, 3'd0, 32'h6FF,      4'd0, 8'd3},   // R3 readback mask
    '{1'b0, 3'd2, 32'h3,        4'd0, 8'd9},   // R9 held at reload
    '{1'b1, 3'd1, 32'h9,        4'd0, 8'd9},   // R9 new reload
    '{1'b0, 3'd2, 32'h9,        4'd0, 8'd9},   // R9 follows reload
    '{1'b1, 3'd0, 32'h0,        4'd0, 8'd10},  // R10 stop ch0
    '{1'b0, 3'd2, 32'h9,        4'd0, 8'd10}   // R10
  };

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic doTicks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic checkRead(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    regAddr = a;
    #1ns;
    checks++;
    if (regRdata !== exp) begin
      fails++;
      $display("FAIL %s addr %0d: got %h expected %h", req, a, regRdata, exp);
    end
  endtask

  task automatic checkIrq(input logic exp, input string req);
    @(negedge clk);
    #1ns;
    checks++;
    if (irqOut !== exp) begin
      fails++;
      $display("FAIL %s irqOut: got %b expected %b", req, irqOut, exp);
    end
  endtask

  initial begin
    #800us;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) checkRead(ADDR_W'(a), 32'h0, "R1");
    checkIrq(1'b0, "R1");

    // vector table
    for (int v = 0; v < NV; v++) begin
      if (VECS[v].isWr) doWrite(VECS[v].addr, VECS[v].data);
      else checkRead(VECS[v].addr, VECS[v].data, $sformatf("R%0d", VECS[v].req));
      doTicks(int'(VECS[v].ticks));
    end

    // R12: idle clocks without tick
    doWrite(3'd1, 32'h5);
    doWrite(3'd0, 32'h82);
    repeat (6) @(negedge clk);
    checkRead(3'd2, 32'h5, "R12");
    doTicks(1);
    checkRead(3'd2, 32'h4, "R6");

    // R5: control write wins over a simultaneous tick
    @(negedge clk);
    regWr = 1'b1; regAddr = 3'd0; regWdata = 32'h82; tickEn = 1'b1;
    @(negedge clk);
    regWr = 1'b0; tickEn = 1'b0;
    checkRead(3'd2, 32'h5, "R5");

    // R11: shared interrupt
    doWrite(3'd1, 32'h0);
    doWrite(3'd0, 32'hC2);
    checkIrq(1'b0, "R11");
    doTicks(1);
    checkIrq(1'b1, "R11");
    doWrite(3'd0, 32'h02);
    checkIrq(1'b0, "R11");
    checkRead(3'd0, 32'h102, "R4");
    doWrite(3'd0, 32'h42);
    checkIrq(1'b1, "R11");
    doWrite(3'd4, 32'h50);
    doWrite(3'd0, 32'h140);
    checkIrq(1'b1, "R11");
    checkRead(3'd0, 32'h40, "R4");
    doWrite(3'd4, 32'h100);
    checkIrq(1'b0, "R11");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule